// File: doc/BRIEF.md
# Priority Interrupt Controller with Sense Control

This block collects interrupt requests from a fixed number of sources and presents one maskable, prioritised request to a single processor core, plus a separate critical request line. Each source owns a vector/priority word that software programs through a simple register strobe: a mask, a 4-bit priority, a trigger-sense bit, a polarity bit and a delivery vector. The core lowers its threshold through a task priority register, and it claims an interrupt by reading an acknowledge location. That read returns the vector and marks the source in service. It later writes an end-of-interrupt location to retire the most urgent in-service entry.

Each source is tied to a class at build time. External sources choose edge or level triggering through their sense bit. Internal sources are always level-triggered. Timer and inter-processor sources are always edge-triggered. Critical sources go straight to the critical output and take no part in priority arbitration or in the acknowledge/EOI handshake. A level source drops out of the pending set as soon as its input falls or its mask is set. A write to the task priority register takes effect on the request output in the next cycle.

Top module: `prio_pic`

## Requirements
- R1: After reset, every source is masked, the task priority is 0, the spurious vector is 0xFF, nothing is pending or in service, and both `int_out` and `crit_out` are low.
- R2: The address map is: addresses 0..NSRC-1 are the per-source words, NSRC is the task priority (bits 3:0), NSRC+1 is acknowledge (read), NSRC+2 is EOI (write), and NSRC+3 is the spurious vector. A per-source word places the mask at bit 31, polarity at bit 23, sense at bit 22, priority at bits 19:16 and the vector at bits 7:0. All other bits read as zero.
- R3: Source classes are external (code 0), internal (1), timer/IPI (2) and critical (3). Internal sources have no sense bit. Timer/IPI and critical sources have neither a sense bit nor a polarity bit. Any bit a class lacks reads as zero whatever is written to it. Polarity is storage only and has no effect on behaviour.
- R4: An external source with sense 1 is level-triggered, and with sense 0 it is edge-triggered on a rising input. Internal sources are always level-triggered and timer/IPI sources always edge-triggered. An edge stays pending after the input falls, until it is acknowledged.
- R5: A level source leaves the pending set when its input is low or its mask bit is 1.
- R6: `int_out` is high exactly when some unmasked, pending, not-in-service, non-critical source has a priority above both the task priority and the highest in-service priority.
- R7: Among eligible sources, the highest priority wins and ties go to the lowest index. An acknowledge read while `int_out` is high returns the winner's vector and marks the winner in service. If the winner is edge-triggered, its pending bit is also cleared.
- R8: An acknowledge read while `int_out` is low returns the spurious vector and changes no state.
- R9: An EOI write clears the highest-priority in-service entry. An EOI with nothing in service is ignored.
- R10: A task priority write raises or lowers `int_out` from the cycle after the write.
- R11: `crit_out` is high while any critical source input is high, regardless of its mask. Critical sources never raise `int_out` and never enter service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NSRC | Active-high source inputs |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (acknowledge side effect) |
| addr | input | ADDR_W | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the current address |
| int_out | output | 1 | Prioritised request to the core |
| crit_out | output | 1 | Critical request to the core |

## Verification
A sweep runs two level-triggered external sources against each other over all 4096 combinations of their two priorities and the task priority. This separates the highest-priority choice, the lowest-index tie rule and the strict-greater threshold, including priority 0, which can never fire. Directed sequences contrast edge and level classes: a short pulse, an input held high after acknowledge, an input that falls, and a mask set while the input is held. A three-deep nesting sequence shows which in-service entry EOI retires and that an extra EOI leaves state intact. Critical inputs are driven while masked to show that the critical path is kept apart from arbitration.

// File: rtl/prio_pic.sv
module prio_pic #(
  parameter int NSRC = 16,
  parameter int VEC_W = 8,
  parameter logic [2*NSRC-1:0] SRC_CLASS = {2'd3, {3{2'd2}}, {4{2'd1}}, {8{2'd0}}},
  localparam int ADDR_W = $clog2(NSRC + 4)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   irq_in,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              int_out,
  output logic              crit_out
);
  localparam int IDX_W = $clog2(NSRC);
  localparam logic [ADDR_W-1:0] A_TPR  = ADDR_W'(NSRC);
  localparam logic [ADDR_W-1:0] A_IACK = ADDR_W'(NSRC + 1);
  localparam logic [ADDR_W-1:0] A_EOI  = ADDR_W'(NSRC + 2);
  localparam logic [ADDR_W-1:0] A_SPUR = ADDR_W'(NSRC + 3);

  logic [NSRC-1:0] is_crit, is_lvl, has_sense, has_pol;
  logic [NSRC-1:0] mask, pol, sense, pend, ins, irq_q, elig;
  logic [3:0]       pri [NSRC];
  logic [VEC_W-1:0] vec [NSRC];
  logic [3:0]       tpr;
  logic [VEC_W-1:0] spur;

  for (genvar g = 0; g < NSRC; g++) begin : g_cls
    assign is_crit[g]   = SRC_CLASS[2*g +: 2] == 2'd3;
    assign has_sense[g] = SRC_CLASS[2*g +: 2] == 2'd0;
    assign has_pol[g]   = SRC_CLASS[2*g +: 2] <= 2'd1;
    assign is_lvl[g]    = (SRC_CLASS[2*g +: 2] == 2'd1) || (has_sense[g] && sense[g]);
  end

  assign elig     = pend & ~mask & ~is_crit & ~ins;
  assign crit_out = |(irq_in & is_crit);

  logic             found, ins_any;
  logic [IDX_W-1:0] sel, ins_idx;
  logic [3:0]       best, ins_pri;

  always_comb begin
    found = 1'b0; sel = '0; best = '0;
    ins_any = 1'b0; ins_idx = '0; ins_pri = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (elig[i] && (!found || pri[i] > best)) begin
        found = 1'b1; sel = IDX_W'(i); best = pri[i];
      end
      if (ins[i] && (!ins_any || pri[i] > ins_pri)) begin
        ins_any = 1'b1; ins_idx = IDX_W'(i); ins_pri = pri[i];
      end
    end
  end

  assign int_out = found && (best > tpr) && (best > ins_pri);

  wire take = rd_en && (addr == A_IACK) && int_out;
  wire eoi  = wr_en && (addr == A_EOI) && ins_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= '1; pol <= '0; sense <= '0; pend <= '0; ins <= '0; irq_q <= '0;
      tpr <= '0; spur <= '1;
      for (int i = 0; i < NSRC; i++) begin
        pri[i] <= '0; vec[i] <= '0;
      end
    end else begin
      irq_q <= irq_in;
      for (int i = 0; i < NSRC; i++) begin
        if (is_lvl[i]) pend[i] <= irq_in[i] & ~mask[i];
        else pend[i] <= (pend[i] & ~(take && sel == IDX_W'(i))) | (irq_in[i] & ~irq_q[i]);
        if (take && sel == IDX_W'(i)) ins[i] <= 1'b1;
        else if (eoi && ins_idx == IDX_W'(i)) ins[i] <= 1'b0;
        if (wr_en && addr == ADDR_W'(i)) begin
          mask[i]  <= wdata[31];
          pol[i]   <= wdata[23] & has_pol[i];
          sense[i] <= wdata[22] & has_sense[i];
          pri[i]   <= wdata[19:16];
          vec[i]   <= wdata[VEC_W-1:0];
        end
      end
      if (wr_en && addr == A_TPR)  tpr  <= wdata[3:0];
      if (wr_en && addr == A_SPUR) spur <= wdata[VEC_W-1:0];
    end
  end

  wire [IDX_W-1:0] ra = addr[IDX_W-1:0];

  always_comb begin
    rdata = '0;
    if (int'(addr) < NSRC) begin
      rdata[31]          = mask[ra];
      rdata[23]          = pol[ra];
      rdata[22]          = sense[ra];
      rdata[19:16]       = pri[ra];
      rdata[VEC_W-1:0]   = vec[ra];
    end else if (addr == A_TPR) begin
      rdata[3:0] = tpr;
    end else if (addr == A_IACK) begin
      rdata[VEC_W-1:0] = int_out ? vec[sel] : spur;
    end else if (addr == A_SPUR) begin
      rdata[VEC_W-1:0] = spur;
    end
  end
endmodule

// File: rtl/prio_pic_sva.sv
module prio_pic_sva #(
  parameter int NSRC = 16,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NSRC-1:0]   irq_in,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic              int_out,
  input logic [NSRC-1:0]   pend,
  input logic [NSRC-1:0]   ins,
  input logic [NSRC-1:0]   mask,
  input logic [NSRC-1:0]   is_lvl,
  input logic [NSRC-1:0]   is_crit
);
  wire iack = rd_en && addr == ADDR_W'(NSRC + 1);
  wire eoi  = wr_en && addr == ADDR_W'(NSRC + 2);

  for (genvar g = 0; g < NSRC; g++) begin : g_lv
    a_r5_level_withdraw: assert property (@(posedge clk) disable iff (!rst_n)
      (is_lvl[g] && (!irq_in[g] || mask[g])) |=> !pend[g]);
  end

  a_r6_out_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> (pend & ~mask & ~is_crit) != '0);

  a_r7_ack_enters_service: assert property (@(posedge clk) disable iff (!rst_n)
    (iack && int_out) |=> $countones(ins) == $past($countones(ins)) + 1);

  a_r8_spurious_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (iack && !int_out) |=> $stable(ins));

  a_r9_empty_eoi: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && ins == '0) |=> ins == '0);

  a_r11_crit_never_served: assert property (@(posedge clk) disable iff (!rst_n)
    (ins & is_crit) == '0);
endmodule

bind prio_pic prio_pic_sva #(.NSRC(NSRC), .ADDR_W(ADDR_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .rd_en(rd_en),
  .addr(addr), .int_out(int_out), .pend(pend), .ins(ins), .mask(mask),
  .is_lvl(is_lvl), .is_crit(is_crit)
);

// File: tb/prio_pic_test.sv
module prio_pic_test;
  localparam int NSRC = 16;
  localparam int AW = 5;
  localparam logic [AW-1:0] TPR = 5'd16, IACK = 5'd17, EOI = 5'd18, SPUR = 5'd19;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0, int_out, crit_out;
  logic [NSRC-1:0] irq_in = '0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata, v;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  prio_pic uut (.clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .rd_en(rd_en),
                .addr(addr), .wdata(wdata), .rdata(rdata), .int_out(int_out), .crit_out(crit_out));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic pulse(int i);
    @(negedge clk); irq_in[i] = 1'b1;
    @(negedge clk); irq_in[i] = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic [31:0] word(bit m, bit s, logic [3:0] p, logic [7:0] vv);
    return {m, 7'd0, 1'b0, s, 2'd0, p, 8'd0, vv};
  endfunction

  initial begin
    #(190000 * 20);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 int_out", {31'd0, int_out}, 0);
    chk("R1 crit_out", {31'd0, crit_out}, 0);
    rd(5'd3, v);  chk("R1 source word", v, 32'h8000_0000);
    rd(TPR, v);   chk("R1 tpr", v, 0);
    rd(SPUR, v);  chk("R1 spurious", v, 32'hFF);
    rd(IACK, v);  chk("R1 iack idle", v, 32'hFF);

    // R2 R3 field layout per class
    for (int i = 0; i < NSRC; i++) begin
      logic [31:0] e;
      wr(AW'(i), 32'hFFFF_FFFF);
      rd(AW'(i), v);
      e = (i < 8) ? 32'h80CF_00FF : (i < 12) ? 32'h808F_00FF : 32'h800F_00FF;
      chk(i < 8 ? "R2 readback" : "R3 class bits", v, e);
      wr(AW'(i), 32'h8000_0000);
    end

    // R6 R7 sweep: level sources 2 and 5, all priority pairs and thresholds
    irq_in[2] = 1'b1; irq_in[5] = 1'b1;
    for (int p2 = 0; p2 < 16; p2++)
      for (int p5 = 0; p5 < 16; p5++)
        for (int t = 0; t < 16; t++) begin
          int mx; bit exp_int; logic [31:0] exp_v;
          wr(5'd2, word(0, 1, 4'(p2), 8'h42));
          wr(5'd5, word(0, 1, 4'(p5), 8'h45));
          wr(TPR, 32'(t));
          @(negedge clk);
          mx = (p2 >= p5) ? p2 : p5;
          exp_int = mx > t;
          exp_v = !exp_int ? 32'hFF : (p2 >= p5) ? 32'h42 : 32'h45;
          chk("R6 threshold", {31'd0, int_out}, {31'd0, exp_int});
          rd(IACK, v);
          chk("R7 winner vector", v, exp_v);
          if (exp_int) wr(EOI, 0);
        end
    irq_in[2] = 1'b0; irq_in[5] = 1'b0;
    wr(5'd2, 32'h8000_0000); wr(5'd5, 32'h8000_0000); wr(TPR, 0);
    @(negedge clk);
    chk("R5 sweep cleanup", {31'd0, int_out}, 0);

    // R4 external edge persists after input falls
    wr(5'd0, word(0, 0, 4'd4, 8'h10));
    pulse(0); @(negedge clk);
    chk("R4 edge pending", {31'd0, int_out}, 1);
    // R9 nesting
    rd(IACK, v); chk("R7 ack src0", v, 32'h10);
    chk("R7 edge cleared", {31'd0, int_out}, 0);
    wr(5'd1, word(0, 0, 4'd9, 8'h11));
    wr(5'd3, word(0, 0, 4'd6, 8'h13));
    pulse(1);
    chk("R6 preempt", {31'd0, int_out}, 1);
    rd(IACK, v); chk("R7 ack src1", v, 32'h11);
    pulse(3);
    chk("R6 below in-service", {31'd0, int_out}, 0);
    wr(EOI, 0);
    chk("R9 eoi highest", {31'd0, int_out}, 1);
    rd(IACK, v); chk("R9 ack src3", v, 32'h13);
    wr(EOI, 0); wr(EOI, 0);
    chk("R9 all retired", {31'd0, int_out}, 0);
    wr(EOI, 0);
    pulse(3);
    rd(IACK, v); chk("R9 empty eoi ignored", v, 32'h13);
    wr(EOI, 0);

    // R4 R5 internal source always level
    wr(5'd8, word(0, 1, 4'd3, 8'h28));
    rd(5'd8, v); chk("R3 internal sense", v, 32'h0003_0028);
    irq_in[8] = 1'b1; @(negedge clk); @(negedge clk);
    chk("R4 internal level", {31'd0, int_out}, 1);
    rd(IACK, v); chk("R7 ack internal", v, 32'h28);
    wr(EOI, 0);
    chk("R4 level reasserts", {31'd0, int_out}, 1);
    irq_in[8] = 1'b0; @(negedge clk); @(negedge clk);
    chk("R5 level deassert", {31'd0, int_out}, 0);

    // R4 timer edge despite sense write
    wr(5'd12, word(0, 1, 4'd7, 8'h3C));
    irq_in[12] = 1'b1; @(negedge clk); @(negedge clk);
    rd(IACK, v); chk("R4 timer ack", v, 32'h3C);
    wr(EOI, 0); @(negedge clk);
    chk("R4 timer edge only", {31'd0, int_out}, 0);
    irq_in[12] = 1'b0;

    // R5 mask withdraws level, R10 threshold writes
    wr(5'd4, word(0, 1, 4'd5, 8'h24));
    irq_in[4] = 1'b1; @(negedge clk); @(negedge clk);
    chk("R5 level up", {31'd0, int_out}, 1);
    wr(5'd4, word(1, 1, 4'd5, 8'h24));
    chk("R5 mask withdraw", {31'd0, int_out}, 0);
    wr(5'd4, word(0, 1, 4'd5, 8'h24)); @(negedge clk);
    chk("R5 unmask", {31'd0, int_out}, 1);
    wr(TPR, 5);
    chk("R10 tpr lowers", {31'd0, int_out}, 0);
    wr(TPR, 4);
    chk("R10 tpr raises", {31'd0, int_out}, 1);
    irq_in[4] = 1'b0; wr(TPR, 0); @(negedge clk);

    // R8 spurious value, R11 critical
    wr(SPUR, 32'h5A);
    rd(SPUR, v); chk("R8 spurious readback", v, 32'h5A);
    @(negedge clk); irq_in[15] = 1'b1; #1;
    chk("R11 crit masked still fires", {31'd0, crit_out}, 1);
    @(negedge clk); @(negedge clk);
    chk("R11 no int_out", {31'd0, int_out}, 0);
    rd(IACK, v); chk("R8 spurious ack", v, 32'h5A);
    wr(5'd1, word(0, 0, 4'd2, 8'h11));
    pulse(1);
    rd(IACK, v); chk("R8 state intact", v, 32'h11);
    wr(EOI, 0);
    @(negedge clk); irq_in[15] = 1'b0; #1;
    chk("R11 crit follows input", {31'd0, crit_out}, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule